// File: doc/BRIEF.md
# Sensorless Motor Start-up Sequencer

This block brings a three-phase brushless motor without position sensors from standstill up to closed-loop commutation. It steps through three modes in a fixed order. In align mode it holds the commutation state machine in its reset state, so the rotor settles into a known position. In ramp mode it produces open-loop commutation ticks from a phase accumulator whose rate rises by a fixed step every clock. In run mode it hands tick generation to the back-EMF loop and raises the sampler and speed-loop enables.

The align and ramp lengths, the starting rate and the acceleration step are inputs, so one netlist can be tuned for different motors and loads. An undervoltage fault acts like a restart. It returns the block to align and clears the timers and the accumulator, so the whole sequence repeats once supply is good again. The ramp rate reached at the end of ramp mode is presented on an output and held there, so the loop can start from the frequency the open-loop ramp already reached.

Top module: `spinup_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after a clock edge at which it was high, the outputs are: mode 00, `comm_reset` 1, `comm_tick` 0, `sense_en` 0, `speed_en` 0, `rate_o` 0.
- R2: After reset or fault is released, mode stays at align (00) with `comm_reset` high for max(`align_len`,1) clock cycles, counting the cycle in which the release is first seen. It then moves to ramp.
- R3: On entry to ramp, `rate_o` is loaded with `rate_init` and the phase accumulator is cleared. On each later ramp cycle the `PW`-bit phase accumulator adds the current rate, and `comm_tick` pulses one cycle later exactly when that addition carries out. The rate then grows by `rate_accel`. `loop_tick` has no effect outside run mode.
- R4: The ramp rate saturates at 2^PW-1 and never wraps.
- R5: Ramp mode (01) lasts max(`ramp_len`,1) cycles, and mode then becomes run (10). `sense_en` and `speed_en` stay low in align and ramp.
- R6: In run mode `comm_tick` equals `loop_tick` in the same cycle, `sense_en` and `speed_en` are 1 and `comm_reset` is 0. Without a fault, run mode persists.
- R7: In run mode `rate_o` holds the rate reached by the last ramp update and stays stable.
- R8: A high `uv_fault` seen at a clock edge puts the block in align, with timers and rate cleared, at that edge. This applies in every mode, and the fault wins over a timer expiring at the same edge. Once the fault is released, the full sequence starts again.
- R9: The mode code is only ever 00 (align), 01 (ramp) or 10 (run).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| align_len | input | TW | Align duration in cycles |
| ramp_len | input | TW | Ramp duration in cycles |
| rate_init | input | PW | Phase increment loaded at ramp entry |
| rate_accel | input | PW | Amount added to the increment per ramp cycle |
| uv_fault | input | 1 | Undervoltage fault, restarts the sequence |
| loop_tick | input | 1 | Commutation tick from the back-EMF loop |
| comm_tick | output | 1 | Commutation advance pulse |
| comm_reset | output | 1 | Holds the commutation machine in its align state |
| mode_o | output | 2 | Mode code: 00 align, 01 ramp, 10 run |
| sense_en | output | 1 | Back-EMF sampler enable |
| speed_en | output | 1 | Speed regulation enable |
| rate_o | output | PW | Current ramp rate, held as handover value in run |

## Verification
Two things can land on the same clock edge: a mode timer expiring and an undervoltage fault. The bench raises the fault in the last align cycle, so it is seen at exactly the edge where align would end. It then requires mode 00 with a zero rate afterwards, and a full restart once the fault drops. Ramp-end and rate saturation also coincide in one scenario, where the rate is pinned at its maximum when the timer expires. In that case the handed-over value must be the saturated one. A per-cycle scoreboard built from the requirements compares mode, tick, enables and rate through every sequence, while `loop_tick` toggles throughout to show it is ignored before run.

// File: rtl/spinup_pkg.sv
package spinup_pkg;

    typedef enum logic [1:0] {
        MODE_ALIGN = 2'b00,
        MODE_RAMP  = 2'b01,
        MODE_RUN   = 2'b10
    } spin_mode_e;

    // Control handed from the mode machine to the ramp generator
    typedef struct packed {
        logic clear;   // reset or fault: zero everything
        logic load;    // entering ramp: load initial rate
        logic step;    // in ramp: advance phase and rate
        logic hold;    // in run: keep handover rate
    } ramp_ctl_t;

endpackage

// File: rtl/spinup_mode_fsm.sv
module spinup_mode_fsm
    import spinup_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fault,
    input  logic [TW-1:0] align_len,
    input  logic [TW-1:0] ramp_len,
    output spin_mode_e    mode,
    output ramp_ctl_t     ctl
);

    logic [TW-1:0] cnt;
    logic [TW:0]   cnt_nx;
    logic [TW-1:0] cur_len;
    logic          expire;
    logic          kill;

    assign kill    = rst | fault;
    assign cnt_nx  = {1'b0, cnt} + {{TW{1'b0}}, 1'b1};
    assign cur_len = (mode == MODE_RAMP) ? ramp_len : align_len;
    assign expire  = (cnt_nx >= {1'b0, cur_len});

    always_comb begin
        ctl.clear = kill;
        ctl.load  = !kill && (mode == MODE_ALIGN) && expire;
        ctl.step  = !kill && (mode == MODE_RAMP);
        ctl.hold  = !kill && (mode == MODE_RUN);
    end

    always_ff @(posedge clk) begin
        if (kill) begin
            mode <= MODE_ALIGN;
            cnt  <= '0;
        end else begin
            unique case (mode)
                MODE_ALIGN: begin
                    if (expire) begin
                        mode <= MODE_RAMP;
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt_nx[TW-1:0];
                    end
                end
                MODE_RAMP: begin
                    if (expire) begin
                        mode <= MODE_RUN;
                        cnt  <= '0;
                    end else begin
                        cnt <= cnt_nx[TW-1:0];
                    end
                end
                MODE_RUN: begin
                    cnt <= '0;
                end
                default: begin
                    mode <= MODE_ALIGN;
                    cnt  <= '0;
                end
            endcase
        end
    end

    // R9: only the three defined codes
    assert_mode_legal_R9: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ALIGN || mode == MODE_RAMP || mode == MODE_RUN));

    // R8: fault forces align with a cleared timer
    assert_fault_to_align_R8: assert property (@(posedge clk) disable iff (rst)
        fault |=> (mode == MODE_ALIGN && cnt == '0));

    // R2: align can only be left towards ramp
    assert_align_exit_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_ALIGN && !fault) |=> (mode == MODE_ALIGN || mode == MODE_RAMP));

    // R6: run persists until a fault
    assert_run_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RUN && !fault) |=> (mode == MODE_RUN));

endmodule

// File: rtl/spinup_ramp.sv
module spinup_ramp
    import spinup_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  ramp_ctl_t     ctl,
    input  logic [PW-1:0] init_rate,
    input  logic [PW-1:0] accel,
    output logic [PW-1:0] rate,
    output logic          tick
);

    localparam logic [PW-1:0] RATE_MAX = '1;

    logic [PW-1:0] phase;
    logic [PW:0]   ph_sum;
    logic [PW:0]   rt_sum;
    logic [PW-1:0] rate_nx;

    assign ph_sum  = {1'b0, phase} + {1'b0, rate};
    assign rt_sum  = {1'b0, rate} + {1'b0, accel};
    assign rate_nx = rt_sum[PW] ? RATE_MAX : rt_sum[PW-1:0];

    always_ff @(posedge clk) begin
        if (ctl.clear) begin
            rate  <= '0;
            phase <= '0;
            tick  <= 1'b0;
        end else if (ctl.load) begin
            rate  <= init_rate;
            phase <= '0;
            tick  <= 1'b0;
        end else if (ctl.step) begin
            phase <= ph_sum[PW-1:0];
            tick  <= ph_sum[PW];
            rate  <= rate_nx;
        end else begin
            tick  <= 1'b0;
        end
    end

    // R3: rate never falls while ramping
    assert_rate_rises_R3: assert property (@(posedge clk) disable iff (ctl.clear)
        ctl.step |=> (rate >= $past(rate)));

    // R4: saturated rate stays at the ceiling
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (ctl.clear)
        (ctl.step && rate == RATE_MAX) |=> (rate == RATE_MAX));

    // R7: handover value is frozen during run
    assert_handover_stable_R7: assert property (@(posedge clk) disable iff (ctl.clear)
        ctl.hold |=> $stable(rate));

endmodule

// File: rtl/spinup_seq.sv
module spinup_seq
    import spinup_pkg::*;
#(
    parameter int TW = 16,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] align_len,
    input  logic [TW-1:0] ramp_len,
    input  logic [PW-1:0] rate_init,
    input  logic [PW-1:0] rate_accel,
    input  logic          uv_fault,
    input  logic          loop_tick,
    output logic          comm_tick,
    output logic          comm_reset,
    output logic [1:0]    mode_o,
    output logic          sense_en,
    output logic          speed_en,
    output logic [PW-1:0] rate_o
);

    spin_mode_e mode;
    ramp_ctl_t  ctl;
    logic       ramp_tick;

    spinup_mode_fsm #(.TW(TW)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .fault     (uv_fault),
        .align_len (align_len),
        .ramp_len  (ramp_len),
        .mode      (mode),
        .ctl       (ctl)
    );

    spinup_ramp #(.PW(PW)) ramp_i (
        .clk       (clk),
        .ctl       (ctl),
        .init_rate (rate_init),
        .accel     (rate_accel),
        .rate      (rate_o),
        .tick      (ramp_tick)
    );

    assign comm_tick  = (mode == MODE_RUN) ? loop_tick : ramp_tick;
    assign comm_reset = (mode == MODE_ALIGN);
    assign sense_en   = (mode == MODE_RUN);
    assign speed_en   = (mode == MODE_RUN);
    assign mode_o     = mode;

    // R6: in run the tick is the loop's tick
    assert_loop_drives_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> (comm_tick == loop_tick));

endmodule

// File: tb/spinup_seq_tb_top.sv
module spinup_seq_tb_top;

    localparam int TW = 16;
    localparam int PW = 16;

    typedef struct packed {
        logic [1:0]    mode;
        logic          tick;
        logic          follow;
        logic [PW-1:0] rate;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] align_len = '0;
    logic [TW-1:0] ramp_len = '0;
    logic [PW-1:0] rate_init = '0;
    logic [PW-1:0] rate_accel = '0;
    logic          uv_fault = 1'b0;
    logic          loop_tick = 1'b0;
    logic          comm_tick, comm_reset, sense_en, speed_en;
    logic [1:0]    mode_o;
    logic [PW-1:0] rate_o;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    spinup_seq #(.TW(TW), .PW(PW)) dut_i (
        .clk(clk), .rst(rst), .align_len(align_len), .ramp_len(ramp_len),
        .rate_init(rate_init), .rate_accel(rate_accel), .uv_fault(uv_fault),
        .loop_tick(loop_tick), .comm_tick(comm_tick), .comm_reset(comm_reset),
        .mode_o(mode_o), .sense_en(sense_en), .speed_en(speed_en), .rate_o(rate_o)
    );

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual: %s expected: %s", tag, act, exp);
        end
    endtask

    function automatic string state_str();
        return $sformatf("mode=%b tick=%b rst=%b sen=%b spd=%b rate=%h",
                         mode_o, comm_tick, comm_reset, sense_en, speed_en, rate_o);
    endfunction

    // loop tick toggles in an irregular pattern all the time
    initial begin
        int k = 0;
        forever begin
            @(posedge clk);
            #1;
            k++;
            loop_tick = (k % 3 == 0) || (k % 7 == 1);
        end
    end

    // monitor: pops one expected item per cycle
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t  e;
                logic  et;
                string tag;
                bit    ok;
                e   = sb_q.pop_front();
                et  = e.follow ? loop_tick : e.tick;
                tag = (e.mode == 2'b00) ? "R2,R9" :
                      (e.mode == 2'b01) ? "R3,R5,R9" : "R6,R7,R9";
                ok  = (mode_o == e.mode) && (comm_tick == et) &&
                      (comm_reset == (e.mode == 2'b00)) &&
                      (sense_en == (e.mode == 2'b10)) &&
                      (speed_en == (e.mode == 2'b10)) && (rate_o == e.rate);
                check(ok, tag, state_str(),
                      $sformatf("mode=%b tick=%b rst=%b sen=%b spd=%b rate=%h",
                                e.mode, et, e.mode == 2'b00, e.mode == 2'b10,
                                e.mode == 2'b10, e.rate));
            end
        end
    end

    // driver: builds the expected sequence from the requirements, then releases
    task automatic run_seq(input int n, input int r, input int init, input int acc,
                           input int run_n, input int limit);
        int            na, nr, pushed;
        logic [PW-1:0] ph, rt, accv;
        logic [PW:0]   s, ra;
        logic          tk;
        exp_t          e;
        na = (n < 1) ? 1 : n;
        nr = (r < 1) ? 1 : r;
        pushed = 0;
        @(posedge clk);
        #1;
        align_len  = TW'(n);
        ramp_len   = TW'(r);
        rate_init  = PW'(init);
        rate_accel = PW'(acc);
        accv = PW'(acc);
        for (int k = 0; k < na; k++) begin
            e = '{mode: 2'b00, tick: 1'b0, follow: 1'b0, rate: '0};
            if (limit < 0 || pushed < limit) begin sb_q.push_back(e); pushed++; end
        end
        ph = '0; rt = PW'(init); tk = 1'b0;
        for (int j = 0; j < nr; j++) begin
            e = '{mode: 2'b01, tick: tk, follow: 1'b0, rate: rt};
            if (limit < 0 || pushed < limit) begin sb_q.push_back(e); pushed++; end
            s  = {1'b0, ph} + {1'b0, rt};
            tk = s[PW];
            ph = s[PW-1:0];
            ra = {1'b0, rt} + {1'b0, accv};
            rt = ra[PW] ? '1 : ra[PW-1:0];
        end
        for (int k = 0; k < run_n; k++) begin
            e = '{mode: 2'b10, tick: 1'b0, follow: 1'b1, rate: rt};
            if (limit < 0 || pushed < limit) begin sb_q.push_back(e); pushed++; end
        end
        rst = 1'b0;
        uv_fault = 1'b0;
        repeat (pushed) @(negedge clk);
    endtask

    // raise fault now (negedge) and check align after the next edge
    task automatic fault_check(input string what);
        uv_fault = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(mode_o == 2'b00 && comm_reset && !sense_en && !speed_en &&
              rate_o == '0 && !comm_tick, "R8", state_str(),
              $sformatf("align, rate 0 (%s)", what));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mode_o == 2'b00 && comm_reset && !comm_tick && !sense_en &&
              !speed_en && rate_o == '0, "R1", state_str(), "mode=00 rst=1 rest 0");

        // nominal start: align 5, ramp 12, then run (R2 R3 R5 R6 R7)
        run_seq(5, 12, 'h1000, 'h0800, 8, -1);
        fault_check("fault during run");

        // saturating ramp (R4)
        run_seq(1, 10, 'hF000, 'h4000, 4, -1);
        check(rate_o == '1, "R4", $sformatf("rate=%h", rate_o), "rate=ffff");
        fault_check("fault after saturated run");

        // abort in mid ramp, then a full restart (R8)
        run_seq(4, 20, 'h0400, 'h0100, 0, 7);
        fault_check("fault mid ramp");
        run_seq(4, 20, 'h0400, 'h0100, 4, -1);
        fault_check("fault after restart");

        // fault on the align expiry edge wins (R8)
        run_seq(6, 5, 'h2000, 'h0100, 0, 6);
        fault_check("fault at align expiry");
        @(negedge clk);
        check(mode_o == 2'b00, "R8", state_str(), "mode=00 while fault held");

        // minimum lengths: zero align and single ramp cycle (R2 R5)
        run_seq(0, 1, 'h8000, 'h8000, 3, -1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual: still running expected: finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule